// File: doc/BRIEF.md
# Programmable LFSR Test Pattern Generator

This block supplies stimulus vectors for built-in self-test of an n-input logic cone. It is an n-stage linear feedback shift register whose feedback polynomial, seed, feedback form and run length are all loaded at runtime. A session is loaded, then started. The register then steps once per clock for the programmed number of patterns and stops with a done flag raised. A new seed or polynomial can be loaded between sessions, which is how reseeding is done.

Two generation modes are provided. In pseudorandom mode a primitive polynomial and a nonzero seed give a maximal-length run of 2^n − 1 distinct vectors. In exhaustive mode the all-zero vector is spliced into that cycle, so a full run covers every one of the 2^n input combinations. In either mode a per-session bit selects the feedback form. In the external form the tapped stages are XORed back into the first stage. In the internal form XOR gates between stages are driven from the last stage.

Top module: `tpg_lfsr_gen`

## Requirements
- R1: After reset, pattern_o is the vector with only bit 0 set, done_o is 0 and serial_o is 1.
- R2: A load_i pulse while the generator is not running is accepted. On the next cycle pattern_o shows the seed and done_o is 0.
- R3: In pseudorandom mode (exh_i=0) an all-zero seed is replaced by the vector with only bit 0 set. In exhaustive mode (exh_i=1) an all-zero seed is kept.
- R4: Stage k (k=1..n) is pattern_o[n-k], and the coefficient C_k is taps_i[k-1]. In the external form (form_i=0) one step gives new stage 1 = XOR of C_k·stage k over all k, and new stage k+1 = old stage k.
- R5: In the internal form (form_i=1) one step gives new stage 1 = old stage n, and new stage k+1 = old stage k XOR (C_k·old stage n).
- R6: In pseudorandom mode, with a primitive polynomial and any legal seed, 2^n − 1 steps visit 2^n − 1 distinct nonzero vectors and return to the seed.
- R7: In exhaustive mode the vector with only bit 0 set steps to all-zero. All-zero steps to the normal successor of that vector. A run of 2^n steps visits all 2^n vectors and returns to the seed.
- R8: A start_i pulse with a nonzero loaded count N makes the register step on exactly N clocks. done_o rises on the cycle after the last step, and done_o and pattern_o then hold until the next accepted load.
- R9: A start_i pulse with a loaded count of 0 raises done_o on the next cycle without any step.
- R10: While the generator is running, load_i is ignored. Seed, polynomial, form, mode and count of the running session are all kept.
- R11: serial_o always equals the last stage, pattern_o[0].
- R12: Coefficient C_n (taps_i[n-1]) is always treated as 1, whatever value is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture seed, taps, form, mode and count |
| seed_i | input | WIDTH | Initial register contents |
| taps_i | input | WIDTH | Coefficient mask, bit k-1 is C_k |
| form_i | input | 1 | 0 external feedback, 1 internal feedback |
| exh_i | input | 1 | 1 inserts the all-zero vector (exhaustive mode) |
| count_i | input | CNT_W | Number of patterns to step |
| start_i | input | 1 | Begin the loaded session |
| pattern_o | output | WIDTH | Parallel pattern, stage 1 at the MSB |
| serial_o | output | 1 | Last stage |
| done_o | output | 1 | Programmed count reached |

## Verification
The bench builds the generator with WIDTH=4 and the default 32-bit count. At that width a complete period is only 15 or 16 steps, so every seed can be swept through a full cycle. The sweep covers both primitive degree-4 polynomials, both feedback forms and both modes. Each step is compared with an arithmetic model, and the distinct states of each run are counted to show maximal length and full coverage. Short directed sessions cover the zero-seed replacement, a zero count, a load arriving mid-run and a mask with the top coefficient cleared.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  // Feedback form chosen per session
  typedef enum logic {
    FB_EXTERNAL = 1'b0,
    FB_INTERNAL = 1'b1
  } fb_form_e;

  // Session sequencing
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/tpg_cfg.sv
module tpg_cfg
  import tpg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [WIDTH-1:0] taps_i,
  input  logic             form_i,
  input  logic             exh_i,
  output logic [WIDTH-1:0] taps_o,
  output fb_form_e         form_o,
  output logic             exh_o
);

  localparam logic [WIDTH-1:0] TOP_COEF = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] taps_q;
  fb_form_e         form_q;
  logic             exh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taps_q <= TOP_COEF;
      form_q <= FB_EXTERNAL;
      exh_q  <= 1'b0;
    end else if (cap_i) begin
      taps_q <= taps_i | TOP_COEF;
      form_q <= fb_form_e'(form_i);
      exh_q  <= exh_i;
    end
  end

  assign taps_o = taps_q;
  assign form_o = form_q;
  assign exh_o  = exh_q;

endmodule

// File: rtl/tpg_step.sv
module tpg_step
  import tpg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic [WIDTH-1:0] taps_i,
  input  fb_form_e         form_i,
  input  logic             exh_i,
  output logic [WIDTH-1:0] next_o,
  output logic             head_zero_o,
  output logic             fb_o
);

  // Stage k lives at state_i[WIDTH-k]; coefficient C_k at taps_i[k-1].
  logic [WIDTH-1:0] tap_terms;
  logic             fb_ext;
  logic             fb_raw;
  logic             is_int;

  genvar k;
  generate
    for (k = 1; k <= WIDTH; k++) begin : g_terms
      assign tap_terms[k-1] = taps_i[k-1] & state_i[WIDTH-k];
    end
  endgenerate

  function automatic logic parity(input logic [WIDTH-1:0] v);
    return ^v;
  endfunction

  assign fb_ext      = parity(tap_terms);
  assign is_int      = (form_i == FB_INTERNAL);
  assign fb_raw      = is_int ? state_i[0] : fb_ext;
  assign head_zero_o = ~|state_i[WIDTH-1:1];
  // Splicing in the all-zero vector: flip feedback when stages 1..n-1 are clear
  assign fb_o        = fb_raw ^ (exh_i & head_zero_o);

  assign next_o[WIDTH-1] = fb_o;
  generate
    for (k = 1; k < WIDTH; k++) begin : g_shift
      assign next_o[WIDTH-1-k] = state_i[WIDTH-k] ^ (is_int & taps_i[k-1] & fb_o);
    end
  endgenerate

endmodule

// File: rtl/tpg_count.sv
module tpg_count
  import tpg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             start_i,
  output logic             cap_o,
  output logic             adv_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e       seq_q;
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (seq_q == SEQ_RUN);
  assign cap_o  = load_i & ~busy_o;
  assign adv_o  = busy_o;
  assign done_o = (seq_q == SEQ_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (seq_q)
        SEQ_IDLE: begin
          if (load_i) begin
            cnt_q <= count_i;
          end else if (start_i) begin
            seq_q <= (cnt_q == '0) ? SEQ_DONE : SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          cnt_q <= cnt_q - ONE;
          if (cnt_q == ONE) seq_q <= SEQ_DONE;
        end
        SEQ_DONE: begin
          if (load_i) begin
            cnt_q <= count_i;
            seq_q <= SEQ_IDLE;
          end
        end
        default: seq_q <= SEQ_IDLE;
      endcase
    end
  end

  // R8: each running cycle consumes one pattern from the count
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (cnt_q == $past(cnt_q) - ONE));

  // R8: done stays up until a load arrives
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> done_o);

  // R9: a start on an empty count goes straight to done
  a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_q == SEQ_IDLE) && !load_i && start_i && (cnt_q == '0)) |=> (done_o && !busy_o));

endmodule

// File: rtl/tpg_lfsr_gen.sv
module tpg_lfsr_gen
  import tpg_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic [WIDTH-1:0] taps_i,
  input  logic             form_i,
  input  logic             exh_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             start_i,
  output logic [WIDTH-1:0] pattern_o,
  output logic             serial_o,
  output logic             done_o
);

  localparam logic [WIDTH-1:0] LSB_ONLY = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             cap;
  logic             adv;
  logic             busy;
  logic [WIDTH-1:0] taps_q;
  fb_form_e         form_q;
  logic             exh_q;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_nxt;
  logic             head_zero;
  logic             fb_bit;

  // An all-zero seed would lock a pseudorandom run; exhaustive mode allows it.
  function automatic logic [WIDTH-1:0] legal_seed(input logic [WIDTH-1:0] s,
                                                  input logic exh);
    return ((s == '0) && !exh) ? LSB_ONLY : s;
  endfunction

  tpg_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .count_i (count_i),
    .start_i (start_i),
    .cap_o   (cap),
    .adv_o   (adv),
    .busy_o  (busy),
    .done_o  (done_o)
  );

  tpg_cfg #(.WIDTH(WIDTH)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (cap),
    .taps_i (taps_i),
    .form_i (form_i),
    .exh_i  (exh_i),
    .taps_o (taps_q),
    .form_o (form_q),
    .exh_o  (exh_q)
  );

  tpg_step #(.WIDTH(WIDTH)) u_step (
    .state_i     (state_q),
    .taps_i      (taps_q),
    .form_i      (form_q),
    .exh_i       (exh_q),
    .next_o      (state_nxt),
    .head_zero_o (head_zero),
    .fb_o        (fb_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LSB_ONLY;
    end else if (cap) begin
      state_q <= legal_seed(seed_i, exh_i);
    end else if (adv) begin
      state_q <= state_nxt;
    end
  end

  assign pattern_o = state_q;
  assign serial_o  = state_q[0];

  // R2: an accepted nonzero seed appears on the pattern output
  a_r2_seed_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && (seed_i != '0)) |=> (pattern_o == $past(seed_i)));

  // R4: the external form shifts stage k into stage k+1
  a_r4_ext_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (form_q == FB_EXTERNAL)) |=> (pattern_o[WIDTH-2:0] == $past(pattern_o[WIDTH-1:1])));

  // R5: the internal form loads stage 1 from the last stage
  a_r5_int_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (form_q == FB_INTERNAL) && !(exh_q && head_zero)) |=> (pattern_o[WIDTH-1] == $past(pattern_o[0])));

  // R6: a pseudorandom run never reaches the all-zero vector
  a_r6_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !exh_q) |=> (pattern_o != '0));

  // R7: exhaustive mode enters all-zero from the lsb-only vector
  a_r7_zero_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && exh_q && (pattern_o == LSB_ONLY)) |=> (pattern_o == '0));

  // R7: and leaves all-zero with stage 1 set
  a_r7_zero_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && exh_q && (pattern_o == '0)) |=> (pattern_o[WIDTH-1] && fb_bit == $past(fb_bit) ? 1'b1 : pattern_o[WIDTH-1]));

  // R10: a load during a run leaves the session configuration alone
  a_r10_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load_i) |=> ($stable(taps_q) && $stable(form_q) && $stable(exh_q)));

endmodule

// File: tb/tpg_lfsr_gen_tb.sv
module tpg_lfsr_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic [W-1:0]  seed_i = '0;
  logic [W-1:0]  taps_i = '0;
  logic          form_i = 1'b0;
  logic          exh_i = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic          start_i = 1'b0;
  logic [W-1:0]  pattern_o;
  logic          serial_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tpg_lfsr_gen #(.WIDTH(W), .CNT_W(CW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .seed_i    (seed_i),
    .taps_i    (taps_i),
    .form_i    (form_i),
    .exh_i     (exh_i),
    .count_i   (count_i),
    .start_i   (start_i),
    .pattern_o (pattern_o),
    .serial_o  (serial_o),
    .done_o    (done_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Stage-indexed model: stage k is bit W-k, coefficient C_k is mask bit k-1, C_W is 1.
  function automatic logic [W-1:0] plain_step(input logic [W-1:0] st,
                                              input logic [W-1:0] msk,
                                              input logic frm);
    logic [W:1] s;
    logic [W:1] c;
    logic [W:1] ns;
    logic [W-1:0] r;
    logic acc;
    for (int k = 1; k <= W; k++) begin
      s[k] = st[W-k];
      c[k] = (k == W) ? 1'b1 : msk[k-1];
    end
    if (!frm) begin
      acc = 1'b0;
      for (int k = 1; k <= W; k++) acc = acc ^ (c[k] & s[k]);
      ns[1] = acc;
      for (int k = 2; k <= W; k++) ns[k] = s[k-1];
    end else begin
      ns[1] = s[W];
      for (int k = 2; k <= W; k++) ns[k] = s[k-1] ^ (c[k-1] & s[W]);
    end
    for (int k = 1; k <= W; k++) r[W-k] = ns[k];
    return r;
  endfunction

  function automatic logic [W-1:0] model_step(input logic [W-1:0] st,
                                              input logic [W-1:0] msk,
                                              input logic frm,
                                              input logic exh);
    if (exh && st == 1) return '0;
    if (exh && st == 0) return plain_step(1, msk, frm);
    return plain_step(st, msk, frm);
  endfunction

  task automatic do_load(input logic [W-1:0] sd, input logic [W-1:0] msk,
                         input logic frm, input logic exh, input int cnt);
    @(negedge clk);
    load_i = 1'b1; seed_i = sd; taps_i = msk; form_i = frm; exh_i = exh; count_i = cnt;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic run_session(input logic [W-1:0] sd, input logic [W-1:0] msk,
                             input logic frm, input logic exh, input int cnt,
                             input logic full_period);
    logic [W-1:0] exp_st;
    logic [W-1:0] first;
    bit seen[1<<W];
    int distinct;
    do_load(sd, msk, frm, exh, cnt);
    first = (sd == 0 && !exh) ? 1 : sd;
    chk(pattern_o == first, "R2/R3 seed load", pattern_o, first);
    chk(done_o == 1'b0, "R2 done cleared", done_o, 0);
    exp_st = first;
    foreach (seen[i]) seen[i] = 1'b0;
    distinct = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 1; i <= cnt; i++) begin
      @(negedge clk);
      exp_st = model_step(exp_st, msk, frm, exh);
      chk(pattern_o == exp_st, frm ? "R5 internal step" : "R4 external step", pattern_o, exp_st);
      chk(serial_o == pattern_o[0], "R11 serial", serial_o, pattern_o[0]);
      chk(done_o == (i == cnt), "R8 done timing", done_o, (i == cnt));
      if (!seen[pattern_o]) distinct++;
      seen[pattern_o] = 1'b1;
    end
    if (full_period) begin
      chk(distinct == cnt, exh ? "R7 distinct" : "R6 distinct", distinct, cnt);
      chk(pattern_o == first, exh ? "R7 return" : "R6 return", pattern_o, first);
      if (!exh) chk(!seen[0], "R6 zero absent", seen[0], 0);
    end
    repeat (2) @(negedge clk);
    chk(pattern_o == exp_st, "R8 pattern holds", pattern_o, exp_st);
    chk(done_o == 1'b1, "R8 done holds", done_o, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] exp_st;
    logic [W-1:0] prim [2];
    prim[0] = 4'b0001;
    prim[1] = 4'b0100;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pattern_o == 4'b0001, "R1 reset pattern", pattern_o, 1);
    chk(done_o == 1'b0, "R1 reset done", done_o, 0);
    chk(serial_o == 1'b1, "R1 reset serial", serial_o, 1);

    // Directed: primitive x^4+x+1 from 1000, 15-state cycle
    run_session(4'b1000, 4'b0001, 1'b0, 1'b0, 15, 1'b1);

    // R3: zero seed in both modes
    run_session(4'b0000, 4'b0001, 1'b0, 1'b0, 15, 1'b1);
    run_session(4'b0000, 4'b0001, 1'b1, 1'b1, 16, 1'b1);

    // R12: top coefficient cleared in the mask behaves as set
    run_session(4'b0110, 4'b0001, 1'b1, 1'b0, 15, 1'b1);
    run_session(4'b0110, 4'b1001, 1'b1, 1'b0, 15, 1'b1);

    // R9: zero count
    do_load(4'b1011, 4'b0001, 1'b0, 1'b0, 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b1, "R9 done at once", done_o, 1);
    chk(pattern_o == 4'b1011, "R9 no step", pattern_o, 4'b1011);
    repeat (2) @(negedge clk);
    chk(pattern_o == 4'b1011, "R9 still no step", pattern_o, 4'b1011);

    // R10: load in mid-run is ignored
    do_load(4'b1000, 4'b0001, 1'b0, 1'b0, 6);
    exp_st = 4'b1000;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      if (i == 3) begin
        load_i = 1'b1; seed_i = 4'b0110; taps_i = 4'b0100; form_i = 1'b1; exh_i = 1'b1; count_i = 3;
      end
      @(negedge clk);
      load_i = 1'b0;
      exp_st = model_step(exp_st, 4'b0001, 1'b0, 1'b0);
      chk(pattern_o == exp_st, "R10 run unaffected", pattern_o, exp_st);
      chk(done_o == (i == 6), "R10 count kept", done_o, (i == 6));
    end
    @(negedge clk);
    chk(pattern_o == exp_st, "R10 no late seed", pattern_o, exp_st);

    // Sweep: every seed, both primitive polynomials, both forms, both modes
    for (int p = 0; p < 2; p++) begin
      for (int f = 0; f < 2; f++) begin
        for (int s = 1; s < 16; s++)
          run_session(W'(s), prim[p], f[0], 1'b0, 15, 1'b1);
        for (int s = 0; s < 16; s++)
          run_session(W'(s), prim[p], f[0], 1'b1, 16, 1'b1);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule